// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block produces the active-low system reset for one clock domain after power-up. It also drives the active-low power-down control of a PLL whose reference clock comes in through a monitored I/O bank. Its reset sources are:

- an asynchronous power-on-reset release,
- an external active-low reset pin,
- a PLL lock flag,
- a device-initialization-done flag.

Two supply-ready status inputs, one for the bank that holds the reset pin and one for the bank that holds the PLL reference clock, decide when the pin and the clock buffer can be trusted.

The system reset goes low asynchronously as soon as any source is active. It returns high only on a rising edge of the target clock, at the end of a clear-on-request flip-flop chain, so every downstream flop leaves reset on the same edge with recovery time met. The PLL lock flag never drives the output directly. It only lets the chain start shifting, so a PLL that gives no clock edges before lock cannot leave synchronous logic half reset. The external pin passes through a two-flop stage that power-on reset clears. While its bank supply is not ready, the pin is ignored. The PLL power-down release is sampled by a two-flop stage on a free-running clock. Every flop in the block is cleared asynchronously by power-on reset.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n_i` is 0, `sys_rst_n_o` and `pll_pd_n_o` are both 0, with no clock edge needed.
- R2: `pll_pd_n_o` stays 0 until both `por_n_i` and `bank_ref_ready_i` are 1. It rises on the 2nd `free_clk_i` rising edge after the later of those two events.
- R3: With `por_n_i` at 1, a fall of `bank_ref_ready_i` returns `pll_pd_n_o` to 0 on the 2nd `free_clk_i` rising edge, not combinationally.
- R4: While `bank_rst_ready_i` is 0, the level of `ext_rst_n_i` has no effect on `sys_rst_n_o`.
- R5: With `por_n_i` and `bank_rst_ready_i` at 1, `ext_rst_n_i` at 0 forces `sys_rst_n_o` to 0 without waiting for a clock edge.
- R6: When a trusted `ext_rst_n_i` returns to 1 and the other sources are ready, `sys_rst_n_o` rises on the (2+STAGES)-th `clk_i` rising edge (default 5).
- R7: `pll_lock_i` at 0 or `init_done_i` at 0 forces `sys_rst_n_o` to 0 without a clock edge. When the last of them returns to 1, `sys_rst_n_o` rises on the STAGES-th `clk_i` rising edge (default 3).
- R8: For every order in which lock, init-done and the pin are cleared, `sys_rst_n_o` stays 0 until the last one clears. The release latency is then set by that last source alone: STAGES, or 2+STAGES when the pin is last.
- R9: After `por_n_i` rises, with all other sources ready, `sys_rst_n_o` rises on the (2+STAGES)-th `clk_i` rising edge.
- R10: A trusted low pulse on `ext_rst_n_i` shorter than a clock period, with no edge inside it, still drives `sys_rst_n_o` to 0. The output then rises on the (2+STAGES)-th edge after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Target clock domain of the system reset |
| free_clk_i | input | 1 | Free-running clock used to time the PLL power-down release |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| bank_rst_ready_i | input | 1 | Supply-ready status of the bank holding the reset pin |
| bank_ref_ready_i | input | 1 | Supply-ready status of the bank holding the PLL reference clock |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| pll_lock_i | input | 1 | PLL lock flag, 1 when locked |
| init_done_i | input | 1 | Device initialization done, 1 when complete |
| sys_rst_n_o | output | 1 | System reset for the target domain, active low |
| pll_pd_n_o | output | 1 | PLL power-down control, active low |

## Verification
The checker watches several behaviours on every clock:

- the output stays low under power-on reset (R1);
- a lost lock, a pending initialization or a trusted pin forces reset at once (R5, R7);
- a release never comes before STAGES consecutive quiet cycles (R8);
- the PLL power-down is released only after the bank status has been seen in its sampler (R2).

Only the bench's scenarios can show the rest:

- exact release latencies, which depend on which source cleared last;
- that the pin is ignored while its bank is down;
- a sub-cycle pin glitch holding reset for the full depth;
- both orders of power-on-reset and bank readiness for the PLL control.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the reset sequencer.
// Assumes: all source flags are active-high "ready" once qualified.
package rstseq_pkg;

    // Depth of the two-flop samplers on the pin and the PLL control
    localparam int PIN_SYNC_DEPTH = 2;
    localparam int PD_SYNC_DEPTH  = 2;

    // Qualified readiness of each reset source
    typedef struct packed {
        logic por_ok;
        logic lock_ok;
        logic init_ok;
        logic pin_ok;
    } rstseq_src_t;

    // True while any source still requests reset
    function automatic logic rstseq_any_pending(input rstseq_src_t s);
        return !(s.por_ok && s.lock_ok && s.init_ok && s.pin_ok);
    endfunction

endpackage

// File: rtl/rstseq_sync_chain.sv
`timescale 1ns/1ps
// Shift chain with an asynchronous active-high clear.
// Clears every stage at once and shifts d_i toward q_o on each clock.
// Assumes: STAGES >= 2; smaller values are raised to 2.
module rstseq_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] stg_q;

    // Clear all stages on request, otherwise shift one place per clock
    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[DEPTH-2:0], d_i};
        end
    end

    assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/rstseq_pin_qualifier.sv
`timescale 1ns/1ps
// Qualifies the external reset pin.
// The pin is trusted only once power-on reset has negated and its bank
// supply is ready. A trusted low level clears the sampler at once. The
// release needs SYNC_DEPTH clean clock edges.
// Assumes: clk_i is the target domain clock.
module rstseq_pin_qualifier #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic bank_ready_i,
    input  logic pin_n_i,
    output logic pin_ok_o
);
    logic trusted;
    logic clr;

    // Pin is believed only when its input buffer is powered
    assign trusted = por_n_i & bank_ready_i;
    // Clear on power-on reset or on a trusted pin assertion
    assign clr     = ~por_n_i | (trusted & ~pin_n_i);

    rstseq_sync_chain #(
        .STAGES (SYNC_DEPTH)
    ) u_pin_sync (
        .clk_i (clk_i),
        .clr_i (clr),
        .d_i   (1'b1),
        .q_o   (pin_ok_o)
    );

endmodule

// File: rtl/rstseq_pll_gate.sv
`timescale 1ns/1ps
// Drives the PLL power-down control (active low).
// The bank-ready status of the reference clock is sampled on a free-running
// clock, so the release and re-assertion are both synchronous. Power-on
// reset forces power-down asynchronously.
// Assumes: free_clk_i runs independently of the PLL.
module rstseq_pll_gate #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic free_clk_i,
    input  logic por_n_i,
    input  logic bank_ready_i,
    output logic pd_n_o
);
    logic clr;

    // Only power-on reset clears the sampler directly
    assign clr = ~por_n_i;

    rstseq_sync_chain #(
        .STAGES (SYNC_DEPTH)
    ) u_pd_sync (
        .clk_i (free_clk_i),
        .clr_i (clr),
        .d_i   (bank_ready_i),
        .q_o   (pd_n_o)
    );

endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
// Reset sequencer top.
// Combines power-on reset, a qualified external pin, PLL lock and
// init-done into one request. The request clears a STAGES-deep release
// chain asynchronously; the chain shifts ones out on clk_i. Lock is never
// used as the reset itself: it only gates the chain.
// Assumes: STAGES >= 2. The reset flops here are asynchronous by function.
module rst_sequencer #(
    parameter int STAGES = 3
) (
    input  logic clk_i,
    input  logic free_clk_i,
    input  logic por_n_i,
    input  logic bank_rst_ready_i,
    input  logic bank_ref_ready_i,
    input  logic ext_rst_n_i,
    input  logic pll_lock_i,
    input  logic init_done_i,
    output logic sys_rst_n_o,
    output logic pll_pd_n_o
);
    import rstseq_pkg::*;

    logic        pin_ok;
    logic        rst_req;
    rstseq_src_t src;

    rstseq_pin_qualifier #(
        .SYNC_DEPTH (PIN_SYNC_DEPTH)
    ) u_pin_qual (
        .clk_i        (clk_i),
        .por_n_i      (por_n_i),
        .bank_ready_i (bank_rst_ready_i),
        .pin_n_i      (ext_rst_n_i),
        .pin_ok_o     (pin_ok)
    );

    rstseq_pll_gate #(
        .SYNC_DEPTH (PD_SYNC_DEPTH)
    ) u_pll_gate (
        .free_clk_i   (free_clk_i),
        .por_n_i      (por_n_i),
        .bank_ready_i (bank_ref_ready_i),
        .pd_n_o       (pll_pd_n_o)
    );

    // Gather source readiness into one record
    always_comb begin
        src.por_ok  = por_n_i;
        src.lock_ok = pll_lock_i;
        src.init_ok = init_done_i;
        src.pin_ok  = pin_ok;
    end

    // Any pending source clears the release chain
    assign rst_req = rstseq_any_pending(src);

    rstseq_sync_chain #(
        .STAGES (STAGES)
    ) u_release (
        .clk_i (clk_i),
        .clr_i (rst_req),
        .d_i   (1'b1),
        .q_o   (sys_rst_n_o)
    );

endmodule

// File: rtl/rst_sequencer_chk.sv
`timescale 1ns/1ps
// Property checker for rst_sequencer, bound to every instance.
// Assumes: clk_i and free_clk_i are running while por_n_i is high.
module rst_sequencer_chk #(
    parameter int STAGES = 3
) (
    input logic clk_i,
    input logic free_clk_i,
    input logic por_n_i,
    input logic bank_rst_ready_i,
    input logic bank_ref_ready_i,
    input logic ext_rst_n_i,
    input logic pll_lock_i,
    input logic init_done_i,
    input logic sys_rst_n_o,
    input logic pll_pd_n_o
);
    localparam int CW = $clog2(STAGES + 1) + 1;

    logic          quiet;
    logic [CW-1:0] quiet_cnt;

    // Sources all ready this cycle (pin counts only when its bank is ready)
    assign quiet = por_n_i & pll_lock_i & init_done_i
                 & (ext_rst_n_i | ~bank_rst_ready_i);

    // Count consecutive quiet cycles, saturating at STAGES
    always_ff @(posedge clk_i) begin
        if (!por_n_i || !quiet) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt < CW'(STAGES)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R1: power-on reset holds both outputs low
    always @(negedge clk_i) begin
        if (!por_n_i) begin
            p_por_hold_r1: assert (!sys_rst_n_o && !pll_pd_n_o)
                else $error("R1 outputs not held under power-on reset");
        end
    end

    // R7: lost lock forces reset
    p_lock_forces_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !pll_lock_i |-> !sys_rst_n_o);

    // R7: pending initialization forces reset
    p_init_forces_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !init_done_i |-> !sys_rst_n_o);

    // R5: trusted pin assertion forces reset
    p_pin_forces_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (bank_rst_ready_i && !ext_rst_n_i) |-> !sys_rst_n_o);

    // R8: release only after STAGES consecutive quiet cycles
    p_release_depth_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        sys_rst_n_o |-> (quiet_cnt >= CW'(STAGES)));

    // R2: power-down release follows a sampled bank-ready status
    p_pd_after_bank_r2: assert property (@(posedge free_clk_i) disable iff (!por_n_i)
        $rose(pll_pd_n_o) |-> $past(bank_ref_ready_i, 2));

endmodule

bind rst_sequencer rst_sequencer_chk #(
    .STAGES (STAGES)
) u_chk (
    .clk_i            (clk_i),
    .free_clk_i       (free_clk_i),
    .por_n_i          (por_n_i),
    .bank_rst_ready_i (bank_rst_ready_i),
    .bank_ref_ready_i (bank_ref_ready_i),
    .ext_rst_n_i      (ext_rst_n_i),
    .pll_lock_i       (pll_lock_i),
    .init_done_i      (init_done_i),
    .sys_rst_n_o      (sys_rst_n_o),
    .pll_pd_n_o       (pll_pd_n_o)
);

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/1ps
// Bench for rst_sequencer: ordering table, then directed cases.
// Inputs change and outputs are sampled 1 ns after a rising edge.
module rst_sequencer_tb;

    localparam int STAGES = 3;
    localparam logic [3:0] LAT_SRC = 4'(STAGES);
    localparam logic [3:0] LAT_PIN = 4'(STAGES + 2);
    // Source ids: 0 lock, 1 init-done, 2 pin. Entry {first, second, last, latency}
    localparam logic [9:0] ORDER_TBL [6] = '{
        {2'd0, 2'd1, 2'd2, LAT_PIN},
        {2'd1, 2'd0, 2'd2, LAT_PIN},
        {2'd0, 2'd2, 2'd1, LAT_SRC},
        {2'd2, 2'd0, 2'd1, LAT_SRC},
        {2'd1, 2'd2, 2'd0, LAT_SRC},
        {2'd2, 2'd1, 2'd0, LAT_SRC}
    };

    logic clk = 1'b0;
    logic por_n, bank_rst, bank_ref, ext_n, lock, init_done;
    logic sys_rst_n, pd_n;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    rst_sequencer #(
        .STAGES (STAGES)
    ) u_dut (
        .clk_i            (clk),
        .free_clk_i       (clk),
        .por_n_i          (por_n),
        .bank_rst_ready_i (bank_rst),
        .bank_ref_ready_i (bank_ref),
        .ext_rst_n_i      (ext_n),
        .pll_lock_i       (lock),
        .init_done_i      (init_done),
        .sys_rst_n_o      (sys_rst_n),
        .pll_pd_n_o       (pd_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic set_src(input logic [1:0] id, input logic v);
        case (id)
            2'd0:    lock      = v;
            2'd1:    init_done = v;
            default: ext_n     = v;
        endcase
    endtask

    initial begin
        por_n = 1'b1; bank_rst = 1'b0; bank_ref = 1'b0;
        ext_n = 1'b1; lock = 1'b0; init_done = 1'b0;
        #1 por_n = 1'b0;
        tick(2);
        chk(sys_rst_n, 1'b0, "R1", "sys under por");
        chk(pd_n, 1'b0, "R1", "pd under por");
        bank_rst = 1'b1; bank_ref = 1'b1; lock = 1'b1; init_done = 1'b1;
        tick(3);
        chk(sys_rst_n, 1'b0, "R1", "sys held with other sources ready");
        chk(pd_n, 1'b0, "R2", "pd held until por negates");
        // por rises last: pd at edge 2, sys at edge 2+STAGES
        por_n = 1'b1;
        tick(1);
        chk(pd_n, 1'b0, "R2", "pd one edge after por");
        tick(1);
        chk(pd_n, 1'b1, "R2", "pd two edges after por");
        tick(STAGES - 1);
        chk(sys_rst_n, 1'b0, "R9", "sys before depth after por");
        tick(1);
        chk(sys_rst_n, 1'b1, "R9", "sys at depth after por");

        // R8: every clearing order of lock, init-done and pin
        for (int v = 0; v < 6; v++) begin
            tick(1);
            lock = 1'b0; init_done = 1'b0; ext_n = 1'b0;
            #1 chk(sys_rst_n, 1'b0, "R8", "sources asserted");
            tick(3);
            for (int k = 0; k < 3; k++) begin
                set_src(ORDER_TBL[v][9-2*k -: 2], 1'b1);
                if (k < 2) begin
                    tick(6);
                    chk(sys_rst_n, 1'b0, "R8", "held while a source pending");
                end else begin
                    tick(int'(ORDER_TBL[v][3:0]) - 1);
                    chk(sys_rst_n, 1'b0, "R8", "before release latency");
                    tick(1);
                    chk(sys_rst_n, 1'b1, "R8", "at release latency");
                end
            end
        end

        // R7: lock loss and recovery
        tick(1);
        lock = 1'b0;
        #1 chk(sys_rst_n, 1'b0, "R7", "lock loss async");
        tick(1);
        lock = 1'b1;
        tick(STAGES - 1);
        chk(sys_rst_n, 1'b0, "R7", "before depth after lock");
        tick(1);
        chk(sys_rst_n, 1'b1, "R7", "at depth after lock");

        // R7: init-done drop
        init_done = 1'b0;
        #1 chk(sys_rst_n, 1'b0, "R7", "init drop async");
        tick(1);
        init_done = 1'b1;
        tick(STAGES);
        chk(sys_rst_n, 1'b1, "R7", "release after init");

        // R5 / R6: trusted pin
        ext_n = 1'b0;
        #1 chk(sys_rst_n, 1'b0, "R5", "pin async assert");
        tick(2);
        ext_n = 1'b1;
        tick(STAGES + 1);
        chk(sys_rst_n, 1'b0, "R6", "before pin depth");
        tick(1);
        chk(sys_rst_n, 1'b1, "R6", "at pin depth");

        // R10: sub-cycle pin glitch
        ext_n = 1'b0;
        #1 ext_n = 1'b1;
        chk(sys_rst_n, 1'b0, "R10", "glitch asserts reset");
        tick(STAGES + 1);
        chk(sys_rst_n, 1'b0, "R10", "held before depth");
        tick(1);
        chk(sys_rst_n, 1'b1, "R10", "release at depth");

        // R4: pin ignored while its bank is down
        bank_rst = 1'b0;
        tick(1);
        ext_n = 1'b0;
        #1 chk(sys_rst_n, 1'b1, "R4", "pin ignored at once");
        tick(8);
        chk(sys_rst_n, 1'b1, "R4", "pin ignored over time");
        bank_rst = 1'b1;
        #1 chk(sys_rst_n, 1'b0, "R5", "pin trusted once bank ready");
        tick(1);
        ext_n = 1'b1;
        tick(STAGES + 2);
        chk(sys_rst_n, 1'b1, "R6", "release after trusted pin");

        // R3: bank status loss re-asserts power-down synchronously
        bank_ref = 1'b0;
        tick(1);
        chk(pd_n, 1'b1, "R3", "pd one edge after bank loss");
        tick(1);
        chk(pd_n, 1'b0, "R3", "pd two edges after bank loss");
        bank_ref = 1'b1;
        tick(2);
        chk(pd_n, 1'b1, "R2", "pd back after bank return");

        // R1 then R2 with bank ready last
        por_n = 1'b0;
        #1 chk(pd_n, 1'b0, "R1", "pd async on por");
        chk(sys_rst_n, 1'b0, "R1", "sys async on por");
        tick(1);
        bank_ref = 1'b0;
        tick(1);
        por_n = 1'b1;
        tick(5);
        chk(pd_n, 1'b0, "R2", "pd held while bank down");
        bank_ref = 1'b1;
        tick(1);
        chk(pd_n, 1'b0, "R2", "pd one edge after bank");
        tick(1);
        chk(pd_n, 1'b1, "R2", "pd two edges after bank");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule